// File: doc/BRIEF.md
# Quantized Sample Output Formatter

This block sits between a receiver's quantizer and its digital sample pins. Each sample has an in-phase and a quadrature level, and each level is one of eight odd integers from -7 to +7. The block turns each level into a 1-, 2- or 3-bit code. The code can be unsigned binary, sign-magnitude or two's complement. The block then places the bits on four pins: two for the in-phase channel (`pin_i1`, `pin_i0`) and two for the quadrature channel (`pin_q1`, `pin_q0`). The 3-bit mode exists only for the in-phase channel. In that mode the least significant bit is carried on the pin that would otherwise carry the quadrature MSB.

Configuration arrives on plain inputs: a format code, a width code and a quadrature enable. A sample strobe captures the levels and the configuration. A small mode state machine stores the decoded width for the captured sample, and a separate output process drives the pins from that state and the captured codes. The usual tie-off is 2-bit sign-magnitude on the in-phase channel only: format 01, width 010, quadrature enable 0.

The mode state machine has four states. MODE_OFF is entered at reset and for any illegal width code. MODE_SIGN is 1 bit, MODE_PAIR is 2 bits and MODE_TRIPLE is 3 bits. There is one transition, called "capture". On a cycle with the strobe high, the machine moves from any state to the state decoded from the width code, which may be the same state. On a cycle with the strobe low, the machine holds its state ("hold").

Top module: `adc_out_formatter`

## Requirements
- R1: Levels arrive as 4-bit two's complement odd values. In 3-bit sign-magnitude, the code is {sign, (|L|-1)/2}, so +1=000, +7=011, -1=100 and -7=111.
- R2: In 3-bit two's complement, positive levels give (L-1)/2 and negative levels give 8+(L-1)/2, so -1=111 and -7=100. Format codes 10 and 11 both select two's complement.
- R3: In 3-bit unsigned binary (format 00), the code is (L+7)/2, so -7=000 and +7=111.
- R4: The 2-bit sign-magnitude code is {sign, |L|>=3}. In the 2-bit two's complement and unsigned formats, the code is the upper two bits of the 3-bit code.
- R5: In 1-bit mode (width 000), the code is the sign. It is 1 for a negative level in sign-magnitude and two's complement, and 0 for a negative level in unsigned binary. The bit goes on I1 (and Q1), and I0 and Q0 are driven low.
- R6: The legal width codes are 000 (1 bit), 010 (2 bits) and 100 (3 bits). A sample captured with any other width code drives all four pins low.
- R7: In 2-bit mode, I1 and Q1 carry the MSB and I0 and Q0 carry the LSB of their own channel.
- R8: In 3-bit mode with the quadrature enable at 1, I1, I0 and Q1 carry the in-phase code from MSB to LSB. Q0 is low, and the quadrature level has no effect on the pins.
- R9: With the quadrature enable at 0, Q1 and Q0 are low. In 3-bit mode, I1 and I0 then carry the top two bits of the in-phase code.
- R10: The pins change only on the clock edge after a cycle with the strobe high, and they reflect that cycle's inputs. Otherwise they hold.
- R11: After reset, all four pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | Sample strobe; captures levels and configuration |
| fmt_sel | input | 2 | 00 unsigned, 01 sign-magnitude, 1x two's complement |
| width_sel | input | 3 | 000 one bit, 010 two bits, 100 three bits |
| q_en | input | 1 | Quadrature channel enable |
| i_level | input | 4 | In-phase level, signed odd value |
| q_level | input | 4 | Quadrature level, signed odd value |
| pin_i1 | output | 1 | In-phase MSB |
| pin_i0 | output | 1 | In-phase LSB or middle bit |
| pin_q1 | output | 1 | Quadrature MSB, or in-phase LSB in 3-bit mode |
| pin_q0 | output | 1 | Quadrature LSB |

## Verification
The hardest corner to reach from the ports is the 3-bit mode. There the Q1 pin belongs to the in-phase channel, so a fault that leaks the quadrature level onto Q1 can hide unless the two levels differ in their low bits. The stimulus sweeps every in-phase level against every format and every width code, with both enable values. It pairs each sample with an unrelated random quadrature level, so a leak shows up as a wrong Q1. Strobe-free cycles with changed inputs follow the samples to show that the pins hold.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_SIGN   = 2'd1,
        MODE_PAIR   = 2'd2,
        MODE_TRIPLE = 2'd3
    } out_mode_e;

    typedef enum logic [1:0] {
        FK_UNSIGNED = 2'd0,
        FK_SIGNMAG  = 2'd1,
        FK_TWOS     = 2'd2
    } fmt_kind_e;

    localparam logic [2:0] WSEL_ONE   = 3'b000;
    localparam logic [2:0] WSEL_TWO   = 3'b010;
    localparam logic [2:0] WSEL_THREE = 3'b100;

    function automatic out_mode_e decode_width(input logic [2:0] wsel);
        out_mode_e m;
        unique case (wsel)
            WSEL_ONE:   m = MODE_SIGN;
            WSEL_TWO:   m = MODE_PAIR;
            WSEL_THREE: m = MODE_TRIPLE;
            default:    m = MODE_OFF;
        endcase
        return m;
    endfunction

    function automatic fmt_kind_e decode_fmt(input logic [1:0] fsel);
        fmt_kind_e k;
        if (fsel[1])
            k = FK_TWOS;
        else if (fsel[0])
            k = FK_SIGNMAG;
        else
            k = FK_UNSIGNED;
        return k;
    endfunction

endpackage

// File: rtl/fmt_level_enc.sv
module fmt_level_enc
    import fmt_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] level,
    input  fmt_kind_e        kind,
    output logic [LVL_W-2:0] code_full,
    output logic [1:0]       code_pair
);
    localparam int CODE_W = LVL_W - 1;
    localparam int IDX_W  = CODE_W - 1;

    logic             sgn;
    logic [LVL_W-1:0] mag;
    logic [LVL_W-1:0] mag_less;
    logic [IDX_W-1:0] idx;

    always_comb begin
        sgn      = level[LVL_W-1];
        mag      = sgn ? (~level + LVL_W'(1)) : level;
        mag_less = mag - LVL_W'(1);
        idx      = mag_less[CODE_W-1:1];
    end

    always_comb begin
        unique case (kind)
            FK_UNSIGNED: code_full = {~sgn, (sgn ? ~idx : idx)};
            FK_SIGNMAG:  code_full = {sgn, idx};
            default:     code_full = {sgn, (sgn ? ~idx : idx)};
        endcase
        if (kind == FK_SIGNMAG)
            code_pair = {sgn, |idx};
        else
            code_pair = code_full[CODE_W-1:CODE_W-2];
    end

endmodule

// File: rtl/fmt_pin_steer.sv
module fmt_pin_steer
    import fmt_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  out_mode_e         mode,
    input  logic              q_on,
    input  logic [CODE_W-1:0] i_full,
    input  logic [1:0]        i_pair,
    input  logic [1:0]        q_pair,
    input  logic              q_sign,
    output logic [3:0]        pins
);
    always_comb begin
        pins = 4'b0000;
        unique case (mode)
            MODE_SIGN: begin
                pins[3] = i_full[CODE_W-1];
                pins[1] = q_on & q_sign;
            end
            MODE_PAIR: begin
                pins[3:2] = i_pair;
                pins[1:0] = q_on ? q_pair : 2'b00;
            end
            MODE_TRIPLE: begin
                pins[3] = i_full[CODE_W-1];
                pins[2] = i_full[CODE_W-2];
                pins[1] = q_on & i_full[CODE_W-3];
            end
            default: pins = 4'b0000;
        endcase
    end

endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
    import fmt_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic [1:0]       fmt_sel,
    input  logic [2:0]       width_sel,
    input  logic             q_en,
    input  logic [LVL_W-1:0] i_level,
    input  logic [LVL_W-1:0] q_level,
    output logic             pin_i1,
    output logic             pin_i0,
    output logic             pin_q1,
    output logic             pin_q0
);
    localparam int CODE_W = LVL_W - 1;
    localparam int NCH    = 2;

    logic [LVL_W-1:0]  lvl_arr  [NCH];
    logic [CODE_W-1:0] full_arr [NCH];
    logic [1:0]        pair_arr [NCH];
    fmt_kind_e         kind;

    assign lvl_arr[0] = i_level;
    assign lvl_arr[1] = q_level;
    assign kind       = decode_fmt(fmt_sel);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        fmt_level_enc #(.LVL_W(LVL_W)) enc_i (
            .level     (lvl_arr[ch]),
            .kind      (kind),
            .code_full (full_arr[ch]),
            .code_pair (pair_arr[ch])
        );
    end

    logic [CODE_W-2:0] unused_q_low_bits;
    assign unused_q_low_bits = full_arr[1][CODE_W-2:0];

    out_mode_e         state_q, state_d;
    logic              q_on_q;
    logic [CODE_W-1:0] i_full_q;
    logic [1:0]        i_pair_q, q_pair_q;
    logic              q_sign_q;
    logic [3:0]        pins;

    always_comb begin
        state_d = state_q;
        if (smp_stb)
            state_d = decode_width(width_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= MODE_OFF;
            q_on_q   <= 1'b0;
            i_full_q <= '0;
            i_pair_q <= '0;
            q_pair_q <= '0;
            q_sign_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (smp_stb) begin
                q_on_q   <= q_en;
                i_full_q <= full_arr[0];
                i_pair_q <= pair_arr[0];
                q_pair_q <= pair_arr[1];
                q_sign_q <= full_arr[1][CODE_W-1];
            end
        end
    end

    fmt_pin_steer #(.CODE_W(CODE_W)) steer_i (
        .mode   (state_q),
        .q_on   (q_on_q),
        .i_full (i_full_q),
        .i_pair (i_pair_q),
        .q_pair (q_pair_q),
        .q_sign (q_sign_q),
        .pins   (pins)
    );

    assign {pin_i1, pin_i0, pin_q1, pin_q0} = pins;

    a_r10_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable({pin_i1, pin_i0, pin_q1, pin_q0}));

    a_r9_quad_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !q_en) |=> (!pin_q1 && !pin_q0));

    a_r6_illegal_width_low: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && width_sel != 3'b000 && width_sel != 3'b010 && width_sel != 3'b100)
        |=> ({pin_i1, pin_i0, pin_q1, pin_q0} == 4'b0000));

    a_r8_triple_q0_low: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && width_sel == 3'b100) |=> !pin_q0);

    a_r5_sign_follows_level: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && width_sel == 3'b000 && fmt_sel == 2'b01)
        |=> (pin_i1 == $past(i_level[LVL_W-1]) && !pin_i0));

endmodule

// File: tb/adc_out_formatter_tb_top.sv
`timescale 1ns/1ps
module adc_out_formatter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic [1:0] fmt_sel = 2'b01;
    logic [2:0] width_sel = 3'b010;
    logic       q_en = 1'b0;
    logic [3:0] i_level = 4'd1;
    logic [3:0] q_level = 4'd1;
    logic       pin_i1, pin_i0, pin_q1, pin_q0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    adc_out_formatter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb   (smp_stb),
        .fmt_sel   (fmt_sel),
        .width_sel (width_sel),
        .q_en      (q_en),
        .i_level   (i_level),
        .q_level   (q_level),
        .pin_i1    (pin_i1),
        .pin_i0    (pin_i0),
        .pin_q1    (pin_q1),
        .pin_q0    (pin_q0)
    );

    function automatic int ref_full(input int lvl, input logic [1:0] f);
        int a;
        a = (lvl < 0) ? -lvl : lvl;
        if (f == 2'b00) return (lvl + 7) / 2;
        if (f == 2'b01) return ((lvl < 0) ? 4 : 0) + (a - 1) / 2;
        if (lvl < 0) return 8 + (lvl - 1) / 2;
        return (lvl - 1) / 2;
    endfunction

    function automatic int ref_pair(input int lvl, input logic [1:0] f);
        int a;
        a = (lvl < 0) ? -lvl : lvl;
        if (f == 2'b01) return ((lvl < 0) ? 2 : 0) + ((a >= 3) ? 1 : 0);
        return ref_full(lvl, f) / 2;
    endfunction

    function automatic logic [3:0] ref_pins(input int il, input int ql,
        input logic [1:0] f, input logic [2:0] w, input logic qe);
        int ci, cq;
        logic [3:0] p;
        p = 4'b0000;
        if (w == 3'b000) begin
            p[3] = ref_full(il, f) >= 4;
            p[1] = qe && (ref_full(ql, f) >= 4);
        end else if (w == 3'b010) begin
            ci = ref_pair(il, f);
            cq = ref_pair(ql, f);
            p[3:2] = 2'(ci);
            if (qe) p[1:0] = 2'(cq);
        end else if (w == 3'b100) begin
            ci = ref_full(il, f);
            p[3] = ci[2];
            p[2] = ci[1];
            p[1] = qe && ci[0];
        end
        return p;
    endfunction

    function automatic string req_tag(input logic [1:0] f, input logic [2:0] w, input logic qe);
        if (w == 3'b000) return "R5";
        if (w == 3'b010) return qe ? "R4,R7" : "R4,R9";
        if (w == 3'b100) begin
            if (!qe) return "R9";
            if (f == 2'b00) return "R3,R8";
            if (f == 2'b01) return "R1,R8";
            return "R2,R8";
        end
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {pin_i1, pin_i0, pin_q1, pin_q0};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pins actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic sample(input int il, input int ql, input logic [1:0] f,
        input logic [2:0] w, input logic qe);
        @(negedge clk);
        i_level   = 4'(il);
        q_level   = 4'(ql);
        fmt_sel   = f;
        width_sel = w;
        q_en      = qe;
        smp_stb   = 1'b1;
        @(negedge clk);
        smp_stb   = 1'b0;
        check(req_tag(f, w, qe), ref_pins(il, ql, f, w, qe));
    endtask

    task automatic hold_check(input logic [3:0] exp);
        @(negedge clk);
        i_level   = 4'($urandom_range(0, 15));
        q_level   = 4'($urandom_range(0, 15));
        fmt_sel   = 2'($urandom_range(0, 3));
        width_sel = 3'($urandom_range(0, 7));
        q_en      = 1'($urandom_range(0, 1));
        @(negedge clk);
        check("R10 hold", exp);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R11 reset", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after release", 4'b0000);

        // Directed corners
        sample(-7, 7, 2'b01, 3'b100, 1'b1);
        sample(-1, -7, 2'b10, 3'b100, 1'b1);
        sample(-7, 3, 2'b00, 3'b100, 1'b1);
        sample(7, -1, 2'b11, 3'b100, 1'b1);
        sample(3, -3, 2'b01, 3'b010, 1'b1);
        sample(-1, 1, 2'b00, 3'b000, 1'b1);
        sample(5, 5, 2'b01, 3'b110, 1'b1);
        sample(-5, 5, 2'b10, 3'b100, 1'b0);
        hold_check(ref_pins(-5, 5, 2'b10, 3'b100, 1'b0));

        // Exhaustive sweep of I level x format x width x enable
        for (int k = 0; k < 8; k++) begin
            for (int f = 0; f < 4; f++) begin
                for (int w = 0; w < 8; w++) begin
                    for (int e = 0; e < 2; e++) begin
                        sample(2 * k - 7, 2 * int'($urandom_range(0, 7)) - 7,
                               2'(f), 3'(w), 1'(e));
                    end
                end
            end
        end

        // Constrained random with interleaved hold checks
        for (int n = 0; n < 300; n++) begin
            int il, ql;
            logic [1:0] f;
            logic [2:0] w;
            logic qe;
            il = 2 * int'($urandom_range(0, 7)) - 7;
            ql = 2 * int'($urandom_range(0, 7)) - 7;
            f  = 2'($urandom_range(0, 3));
            w  = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7))
                                              : 3'(2 * $urandom_range(0, 2));
            qe = 1'($urandom_range(0, 1));
            sample(il, ql, f, w, qe);
            if (n % 10 == 0) hold_check(ref_pins(il, ql, f, w, qe));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule